// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register front end that sits between a host bus and a three-channel interval timer. The host sees four byte locations. Locations 0, 1 and 2 are the data ports of channels 0, 1 and 2. Location 3 is the control port.

Writes to the control port do three jobs:
- program a channel's access width, operating mode and decimal flag;
- freeze a channel's count;
- issue a multi-channel read-back command, which can freeze counts, capture status bytes, or both.

Data port writes are assembled into 16-bit reload values, which go to the counting logic with a one-cycle load strobe. Data port reads return one of three things: a captured status byte, a frozen count, or the live count. The block only samples each channel's live count and output level. It does no counting itself.

Each channel keeps its own read byte toggle and write byte toggle for word access. A frozen count stays put until every byte of it has been read. A captured status byte is returned ahead of a frozen count.

Top module: `tmr_host_if`

## Requirements
- R1: A control-port write with channel field wr_data[7:6] in 0..2 and a nonzero access field wr_data[5:4] does the following for that channel:
  - stores the access field (1 = low byte only, 2 = high byte only, 3 = low then high);
  - stores wr_data[0] as the decimal flag;
  - stores wr_data[3:1] as the mode, except that modes 6 and 7 are stored as 2 and 3.
  The stored mode and flag appear on ch_mode and ch_bcd one cycle later. All of these are zero after reset.
- R2: A programming write (R1) restarts both the read and the write byte toggle of its channel, so the next data read and the next data write both address the low byte.
- R3: A control-port write with access field 0 freezes the selected channel's live count. Reads then return the frozen bytes, whatever the live count does meanwhile:
  - in low-only or high-only access, one byte, after which the freeze ends;
  - in word access, low byte then high byte, after which the freeze ends.
- R4: A control-port write with channel field 3 is a read-back command. Bit 1+n selects channel n. For each selected channel, bit 5 = 0 freezes its count and bit 4 = 0 captures its status.
- R5: A count-freeze request on a channel whose frozen count is not yet fully read has no effect. The same holds for a status capture on a channel whose status byte is still unread.
- R6: The status byte is laid out as follows:

  | Bit | Content |
  |-----|---------|
  | 7 | output level |
  | 6 | always 0 |
  | 5:4 | access field |
  | 3:1 | stored mode |
  | 0 | decimal flag |

  A pending status byte is returned by the next data read of its channel, before any frozen count. That read clears it.
- R7: A data write loads a value according to the channel's access field:
  - high-only loads {byte, 8'h00};
  - low-only loads {8'h00, byte};
  - word access holds the first byte as the low half and loads {second byte, first byte} on the second write.
  The load appears on ch_load_val with a one-cycle ch_load pulse in the cycle after the completing write.
- R8: With nothing frozen, a data read returns the live count as follows:
  - low-only access returns bits 7:0;
  - high-only access returns bits 15:8;
  - word access returns low and high bytes alternately, starting with the low byte.
- R9: A channel that has never been programmed handles data reads, data writes and count freezes as in low-only access.
- R10: rd_data is zero while rd_en is low and on reads of the control port. It is driven combinationally from the current state while rd_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Byte location: 0..2 channel data, 3 control |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte |
| ch_count | input | 48 | Live count of each channel, 16 bits per channel, channel n at [16n+15:16n] |
| ch_out | input | 3 | Output level of each channel |
| ch_mode | output | 9 | Stored mode per channel, channel n at [3n+2:3n] |
| ch_bcd | output | 3 | Stored decimal flag per channel |
| ch_load | output | 3 | One-cycle reload strobe per channel |
| ch_load_val | output | 48 | Reload value per channel, 16 bits each |

## Verification
The bench first touches an unprogrammed channel, which shows that byte-only behaviour is the default. It then programs word, high-only and folded-mode channels, which separates the three write assemblies and the alternating live reads. A word write interrupted by reprogramming shows whether the toggles restart.

Count freezes are issued while the live count keeps changing. A second freeze is issued while the first is still pending, which tells a held capture apart from a recapture. A combined read-back with the output level high, followed by a status-only read-back repeated with a new output level, checks that status comes out ahead of the frozen count and that a second capture is dropped while one is pending.

Every read and every cycle's load, mode and decimal outputs are compared with a behavioural model.

// File: rtl/tmr_host_pkg.sv
`timescale 1ns/1ps
package tmr_host_pkg;
    localparam int NCH    = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH);

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,   // latch command / unprogrammed / nothing frozen
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e                acc;
        logic [MODE_W-1:0]   mode;
        logic                bcd;
        logic                wflip;
        logic                rflip;
        logic [BYTE_W-1:0]   wlo;
        logic [CNT_W-1:0]    cnt_lat;
        acc_e                cnt_pend;
        logic [BYTE_W-1:0]   sts;
        logic                sts_pend;
        logic                load;
        logic [CNT_W-1:0]    load_val;
    } chan_st_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
`timescale 1ns/1ps
module tmr_ctl_decode
    import tmr_host_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NCH-1:0]    ctl_wr,
    output logic [NCH-1:0]    lat_cnt,
    output logic [NCH-1:0]    lat_sts,
    output logic [NCH-1:0]    data_wr,
    output logic [NCH-1:0]    data_rd
);
    logic       ctl_sel;
    logic [1:0] chan_f;
    logic [1:0] acc_f;
    logic       rb_cmd;

    always_comb begin
        ctl_sel = wr_en && (addr == CTRL_ADDR);
        chan_f  = wr_data[7:6];
        acc_f   = wr_data[5:4];
        rb_cmd  = ctl_sel && (chan_f == 2'd3);
        for (int n = 0; n < NCH; n++) begin
            data_wr[n] = wr_en && (addr == ADDR_W'(n));
            data_rd[n] = rd_en && (addr == ADDR_W'(n));
            ctl_wr[n]  = ctl_sel && (chan_f == 2'(n)) && (acc_f != 2'd0);
            lat_cnt[n] = (ctl_sel && (chan_f == 2'(n)) && (acc_f == 2'd0))
                       || (rb_cmd && wr_data[1+n] && !wr_data[5]);
            lat_sts[n] = rb_cmd && wr_data[1+n] && !wr_data[4];
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              lat_cnt,
    input  logic              lat_sts,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rdata,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);
    chan_st_t q, d;
    logic [MODE_W-1:0] mode_raw;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        rdata  = '0;

        // read path: status, then frozen count, then live count
        if (q.sts_pend) begin
            rdata = q.sts;
            if (data_rd) d.sts_pend = 1'b0;
        end else if (q.cnt_pend != ACC_NONE) begin
            unique case (q.cnt_pend)
                ACC_HI: begin
                    rdata = q.cnt_lat[CNT_W-1:BYTE_W];
                    if (data_rd) d.cnt_pend = ACC_NONE;
                end
                ACC_WORD: begin
                    rdata = q.cnt_lat[BYTE_W-1:0];
                    if (data_rd) d.cnt_pend = ACC_HI;
                end
                default: begin
                    rdata = q.cnt_lat[BYTE_W-1:0];
                    if (data_rd) d.cnt_pend = ACC_NONE;
                end
            endcase
        end else begin
            unique case (q.acc)
                ACC_HI:   rdata = live_count[CNT_W-1:BYTE_W];
                ACC_WORD: begin
                    rdata = q.rflip ? live_count[CNT_W-1:BYTE_W]
                                    : live_count[BYTE_W-1:0];
                    if (data_rd) d.rflip = !q.rflip;
                end
                default:  rdata = live_count[BYTE_W-1:0];
            endcase
        end

        // write assembly
        if (data_wr) begin
            unique case (q.acc)
                ACC_HI: begin
                    d.load     = 1'b1;
                    d.load_val = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (!q.wflip) begin
                        d.wlo   = wdata;
                        d.wflip = 1'b1;
                    end else begin
                        d.load     = 1'b1;
                        d.load_val = {wdata, q.wlo};
                        d.wflip    = 1'b0;
                    end
                end
                default: begin
                    d.load     = 1'b1;
                    d.load_val = {{BYTE_W{1'b0}}, wdata};
                end
            endcase
        end

        // captures, ignored while an earlier one is unread
        if (lat_cnt && (q.cnt_pend == ACC_NONE)) begin
            d.cnt_lat  = live_count;
            d.cnt_pend = (q.acc == ACC_NONE) ? ACC_LO : q.acc;
        end
        if (lat_sts && !q.sts_pend) begin
            d.sts      = {out_lvl, 1'b0, q.acc, q.mode, q.bcd};
            d.sts_pend = 1'b1;
        end

        // programming word (last, so it wins over a same-cycle read toggle)
        mode_raw = wdata[3:1];
        if (ctl_wr) begin
            d.acc   = acc_e'(wdata[5:4]);
            d.mode  = (mode_raw[2] && mode_raw[1]) ? {1'b0, mode_raw[1:0]} : mode_raw;
            d.bcd   = wdata[0];
            d.wflip = 1'b0;
            d.rflip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode_o     = q.mode;
    assign bcd_o      = q.bcd;
    assign load_o     = q.load;
    assign load_val_o = q.load_val;

    AST_CTL_RESTARTS_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!q.wflip && !q.rflip)); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.cnt_pend != ACC_NONE) && !data_rd) |=> $stable(q.cnt_lat)); // R5
    AST_STS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts_pend && !data_rd) |=> $stable(q.sts)); // R5
    AST_STS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts_pend && data_rd) |=> !q.sts_pend); // R6
    AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        q.load |-> $past(data_wr)); // R7
endmodule

// File: rtl/tmr_host_if.sv
`timescale 1ns/1ps
module tmr_host_if
    import tmr_host_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [BYTE_W-1:0]       rd_data,
    input  logic [NCH*CNT_W-1:0]    ch_count,
    input  logic [NCH-1:0]          ch_out,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_bcd,
    output logic [NCH-1:0]          ch_load,
    output logic [NCH*CNT_W-1:0]    ch_load_val
);
    logic [NCH-1:0]    ctl_wr, lat_cnt, lat_sts, data_wr, data_rd;
    logic [BYTE_W-1:0] ch_rdata [NCH];

    tmr_ctl_decode u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_data (wr_data),
        .ctl_wr  (ctl_wr),
        .lat_cnt (lat_cnt),
        .lat_sts (lat_sts),
        .data_wr (data_wr),
        .data_rd (data_rd)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        tmr_chan_regs u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_wr     (ctl_wr[n]),
            .lat_cnt    (lat_cnt[n]),
            .lat_sts    (lat_sts[n]),
            .data_wr    (data_wr[n]),
            .data_rd    (data_rd[n]),
            .wdata      (wr_data),
            .live_count (ch_count[n*CNT_W +: CNT_W]),
            .out_lvl    (ch_out[n]),
            .rdata      (ch_rdata[n]),
            .mode_o     (ch_mode[n*MODE_W +: MODE_W]),
            .bcd_o      (ch_bcd[n]),
            .load_o     (ch_load[n]),
            .load_val_o (ch_load_val[n*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NCH; n++) begin
            if (rd_en && (addr == ADDR_W'(n))) rd_data = ch_rdata[n];
        end
    end

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load)); // R7
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || addr == CTRL_ADDR) |-> (rd_data == '0)); // R10
endmodule

// File: tb/tb_tmr_host_if.sv
`timescale 1ns/1ps
module tb_tmr_host_if;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  addr = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  wr_data = 0;
    logic [7:0]  rd_data;
    logic [47:0] ch_count = 0;
    logic [2:0]  ch_out = 0;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd, ch_load;
    logic [47:0] ch_load_val;

    always #10 clk = ~clk;

    tmr_host_if dut (.*);

    int errors = 0, checks = 0;
    bit done = 0;

    // behavioural model
    int m_acc[3], m_mode[3], m_bcd[3], m_wf[3], m_rf[3], m_wlo[3];
    int m_lat[3];      // frozen count value
    int m_lbytes[3];   // frozen bytes left to read; for word, 2 then 1
    int m_lhi[3];      // 1: next frozen byte is the high byte
    int m_sts[3], m_sp[3];
    int e_load[3], e_val[3], n_load[3], n_val[3];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int live(int c);
        return int'(ch_count[c*16 +: 16]);
    endfunction

    function automatic int exp_read(int a);
        if (a == 3) return 0;
        if (m_sp[a] != 0) return m_sts[a];
        if (m_lbytes[a] != 0) return m_lhi[a] != 0 ? (m_lat[a] >> 8) & 255 : m_lat[a] & 255;
        if (m_acc[a] == 2) return (live(a) >> 8) & 255;
        if (m_acc[a] == 3) return m_rf[a] != 0 ? (live(a) >> 8) & 255 : live(a) & 255;
        return live(a) & 255;
    endfunction

    task automatic m_latch(int c);
        if (m_lbytes[c] == 0) begin
            m_lat[c] = live(c);
            m_lbytes[c] = (m_acc[c] == 3) ? 2 : 1;
            m_lhi[c] = (m_acc[c] == 2) ? 1 : 0;
        end
    endtask

    task automatic m_apply(bit we, bit re, int a, int d);
        for (int c = 0; c < 3; c++) begin n_load[c] = 0; n_val[c] = e_val[c]; end
        if (re && a != 3) begin
            if (m_sp[a] != 0) m_sp[a] = 0;
            else if (m_lbytes[a] != 0) begin
                m_lbytes[a]--;
                m_lhi[a] = 1;
            end else if (m_acc[a] == 3) m_rf[a] = 1 - m_rf[a];
        end
        if (we && a != 3) begin
            if (m_acc[a] == 2) begin n_load[a] = 1; n_val[a] = d << 8; end
            else if (m_acc[a] == 3) begin
                if (m_wf[a] == 0) begin m_wlo[a] = d; m_wf[a] = 1; end
                else begin n_load[a] = 1; n_val[a] = (d << 8) | m_wlo[a]; m_wf[a] = 0; end
            end else begin n_load[a] = 1; n_val[a] = d; end
        end
        if (we && a == 3) begin
            int sel = (d >> 6) & 3;
            int ac = (d >> 4) & 3;
            if (sel == 3) begin
                for (int c = 0; c < 3; c++) if (((d >> (1 + c)) & 1) != 0) begin
                    if (((d >> 5) & 1) == 0) m_latch(c);
                    if (((d >> 4) & 1) == 0 && m_sp[c] == 0) begin
                        m_sts[c] = (int'(ch_out[c]) << 7) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
                        m_sp[c] = 1;
                    end
                end
            end else if (ac == 0) m_latch(sel);
            else begin
                int md = (d >> 1) & 7;
                if (md > 5) md -= 4;
                m_acc[sel] = ac; m_mode[sel] = md; m_bcd[sel] = d & 1;
                m_wf[sel] = 0; m_rf[sel] = 0;
            end
        end
    endtask

    // one bus cycle: compare outputs, drive, check read, advance model
    task automatic cyc(bit we, bit re, int a, int d, string tag);
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            chk("R7 load strobe", int'(ch_load[c]), e_load[c]);
            if (e_load[c] != 0) chk("R7 load value", int'(ch_load_val[c*16 +: 16]), e_val[c]);
            chk("R1 mode", int'(ch_mode[c*3 +: 3]), m_mode[c]);
            chk("R1 bcd", int'(ch_bcd[c]), m_bcd[c]);
        end
        wr_en = we; rd_en = re; addr = 2'(a); wr_data = 8'(d);
        #5;
        if (re) chk(tag, int'(rd_data), exp_read(a));
        else chk("R10 idle read", int'(rd_data), 0);
        m_apply(we, re, a, d);
        @(posedge clk);
        #1;
        for (int c = 0; c < 3; c++) begin e_load[c] = n_load[c]; e_val[c] = n_val[c]; end
    endtask

    task automatic wr(int a, int d, string tag); cyc(1, 0, a, d, tag); endtask
    task automatic rd(int a, string tag);        cyc(0, 1, a, 0, tag); endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 0; m_mode[c] = 0; m_bcd[c] = 0; m_wf[c] = 0; m_rf[c] = 0; m_wlo[c] = 0;
            m_lat[c] = 0; m_lbytes[c] = 0; m_lhi[c] = 0; m_sts[c] = 0; m_sp[c] = 0;
            e_load[c] = 0; e_val[c] = 0; n_load[c] = 0; n_val[c] = 0;
        end
        ch_count = {16'h3344, 16'h2211, 16'h1234};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cyc(0, 0, 0, 0, "R10 reset");               // R1 reset values, R10 quiet bus
        // R9: unprogrammed channel acts as low-only
        wr(0, 8'h34, "R9 write");
        rd(0, "R9 live read");
        wr(3, 8'h80, "R9 latch unprogrammed ch2");
        ch_count[32 +: 16] = 16'h7777;
        rd(2, "R9 frozen single byte");
        rd(2, "R9 live after freeze");
        // R1: word access, mode 2
        wr(3, 8'h34, "R1 program ch0");
        wr(0, 8'h78, "R7 word low");
        wr(0, 8'h56, "R7 word high");
        rd(0, "R8 word live low");
        rd(0, "R8 word live high");
        rd(0, "R8 word live low again");
        // R2: reprogram in the middle of a word write and read
        wr(0, 8'hAA, "R2 half write");
        rd(0, "R2 half read");
        wr(3, 8'h36, "R2 reprogram");
        wr(0, 8'h11, "R2 low after restart");
        wr(0, 8'h22, "R2 high after restart");
        rd(0, "R2 read low after restart");
        // R1: mode 7 folds to 3, decimal flag, high-only
        wr(3, 8'h6F, "R1 program ch1");
        wr(1, 8'hAB, "R7 high-only write");
        rd(1, "R8 high-only live read");
        // R3 and R5: freeze ch0 word, change live, repeat freeze
        wr(3, 8'h00, "R3 latch ch0");
        ch_count[15:0] = 16'h9999;
        wr(3, 8'h00, "R5 repeat latch ignored");
        rd(0, "R3 frozen low");
        ch_count[15:0] = 16'hBEEF;
        rd(0, "R3 frozen high");
        rd(0, "R8 live after freeze");
        // R4 and R6: read-back of count and status on ch0 and ch1
        ch_out = 3'b001;
        ch_count[15:0] = 16'hC0DE;
        wr(3, 8'hC6, "R4 read-back both");
        ch_out = 3'b110;
        ch_count = {16'h0000, 16'h5A5A, 16'h0000};
        rd(0, "R6 status first");
        rd(0, "R4 frozen low");
        rd(0, "R4 frozen high");
        rd(1, "R6 status ch1");
        rd(1, "R4 frozen high-only byte");
        // R5: second status capture ignored while pending
        wr(3, 8'hE4, "R4 status-only ch1");
        ch_out = 3'b000;
        wr(3, 8'hE4, "R5 status repeat ignored");
        rd(1, "R5 held status");
        rd(1, "R6 status cleared, live");
        // R10: control port read
        rd(3, "R10 control read");
        cyc(0, 0, 0, 0, "R10 idle");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule